// File: doc/BRIEF.md
# Serial-Bus Digital Potentiometer Command Decoder

This block is the two-wire serial slave front end of a single-channel, 256-tap digital potentiometer. It watches SCL and SDA through a free-running system clock. It checks the address byte against a fixed device-type code and three strap pins. It then decodes a packed instruction byte and runs the command that the byte names. The results are an 8-bit wiper position and four 8-bit data registers, all held in flip-flops.

There are three kinds of command. A transfer command is two bytes long and is applied at the closing STOP. A write command adds one data byte and is also applied at STOP. A read command returns one register serially. A step command treats every following SCL clock as one move of the wiper, up or down, until STOP. The slave only ever pulls SDA low; the board supplies the wired-AND.

Top module: `dpot_i2c_decoder`

## Requirements
- R1: After reset the wiper and all four data registers hold 0 and SDA is released.
- R2: The first byte after a START is acknowledged only when its bits 7:4 are 0101 and its bits 3:1 equal strap_i[2:0]; bit 0 has no effect on matching. The slave turns its SDA drive on only while SCL is low.
- R3: After an address mismatch SDA stays released, no later byte is acknowledged and no register changes until the next START.
- R4: In the instruction byte, bits 7:4 are the opcode, bits 3:2 are a register select n that names dreg_q[8n+7:8n], and bits 1:0 are a pot select. The byte is acknowledged only for opcodes 1001, 1010, 1011, 1100, 1101, 1110 and 0010. Opcodes 1010, 1011, 1101, 1110 and 0010 also need pot select 00. A refused byte is not acknowledged, and nothing else happens until the next START.
- R5: Opcode 1100 followed by a data byte, which is acknowledged, loads that byte into the selected data register at the closing STOP.
- R6: Opcode 1011 followed by a data byte, which is acknowledged, loads that byte into the wiper at the closing STOP.
- R7: Opcode 1101 copies the selected data register into the wiper, and opcode 1110 copies the wiper into the selected data register. Each takes effect at the STOP that follows the instruction byte.
- R8: Opcode 1001 returns the selected data register and opcode 1010 returns the wiper, MSB first, starting after the instruction acknowledge. A master ACK makes the slave send the same register again, and a master NACK ends the read.
- R9: After opcode 0010, each SCL clock is one step. It is sampled while SCL is high and applied when SCL falls: SDA high adds one to the wiper, SDA low subtracts one. This goes on until STOP, and a clock cut short by STOP has no effect.
- R10: Stepping saturates: an up step at 255 and a down step at 0 leave the wiper unchanged.
- R11: A START or STOP inside a byte, or a START in place of the closing STOP, abandons the command and leaves every register unchanged. The wiper changes only through a step or a STOP commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, free running, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap_i | input | 3 | Board strap bits compared with address bits 3:1 |
| sda_oe | output | 1 | High pulls SDA low (acknowledge or read data 0) |
| wiper_q | output | 8 | Wiper counter position |
| dreg_q | output | 32 | Data registers, register n in bits 8n+7:8n |

## Verification
A wiper step and the saturation clamp act in the same cycle whenever the wiper sits at 0 or 255. The bench provokes this by writing the wiper close to a rail and then sending a long run of steps in one direction; it expects the wiper to stop at the rail and stay there. A STOP can also fall in the cycle that would otherwise have applied a pending step. Every step command therefore ends with a STOP whose rising SCL carries a low SDA. The bench judges this by checking that this cut-off clock never moves the wiper, compared against its own model.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int WW      = 8;
  localparam int NREG    = 4;
  localparam int SELW    = $clog2(NREG);
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = $clog2(BYTE_W) + 1;

  localparam logic [3:0] DEV_TYPE  = 4'b0101;
  localparam logic [3:0] OP_STEP   = 4'b0010;
  localparam logic [3:0] OP_RD_DR  = 4'b1001;
  localparam logic [3:0] OP_RD_WC  = 4'b1010;
  localparam logic [3:0] OP_WR_WC  = 4'b1011;
  localparam logic [3:0] OP_WR_DR  = 4'b1100;
  localparam logic [3:0] OP_DR2WC  = 4'b1101;
  localparam logic [3:0] OP_WC2DR  = 4'b1110;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_INSTR, S_INSTR_ACK, S_DATA,
    S_DATA_ACK, S_HOLD, S_RD, S_RD_ACK, S_STEP, S_IGNORE
  } state_e;

  function automatic logic addr_match(input logic [BYTE_W-1:0] b,
                                      input logic [2:0] strap);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == strap);
  endfunction

  function automatic logic op_known(input logic [3:0] op);
    case (op)
      OP_STEP, OP_RD_DR, OP_RD_WC, OP_WR_WC,
      OP_WR_DR, OP_DR2WC, OP_WC2DR: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic op_uses_wiper(input logic [3:0] op);
    case (op)
      OP_STEP, OP_RD_WC, OP_WR_WC, OP_DR2WC, OP_WC2DR: return 1'b1;
      default:                                         return 1'b0;
    endcase
  endfunction

  function automatic logic instr_ok(input logic [BYTE_W-1:0] b);
    return op_known(b[7:4]) && (!op_uses_wiper(b[7:4]) || (b[1:0] == 2'b00));
  endfunction

  function automatic state_e after_instr(input logic [3:0] op);
    case (op)
      OP_RD_DR, OP_RD_WC: return S_RD;
      OP_WR_DR, OP_WR_WC: return S_DATA;
      OP_DR2WC, OP_WC2DR: return S_HOLD;
      OP_STEP:            return S_STEP;
      default:            return S_IGNORE;
    endcase
  endfunction

  function automatic logic [WW-1:0] sat_step(input logic [WW-1:0] w, input logic up);
    if (up) return (w == {WW{1'b1}}) ? w : w + 1'b1;
    else    return (w == '0) ? w : w - 1'b1;
  endfunction

  function automatic logic [WW-1:0] pick_reg(input logic [NREG*WW-1:0] v,
                                             input logic [SELW-1:0] s);
    return v[s*WW +: WW];
  endfunction
endpackage

// File: rtl/dpot_bus_sync.sv
module dpot_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_pipe <= '1; sda_pipe <= '1; end
        else begin scl_pipe <= scl_i; sda_pipe <= sda_i; end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_pipe <= '1; sda_pipe <= '1; end
        else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_d <= 1'b1; sda_d <= 1'b1; end
    else begin scl_d <= scl_s; sda_d <= sda_s; end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs import dpot_pkg::*; #(
  parameter logic [WW-1:0] WC_RST = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_wc,
  input  logic [WW-1:0]        wc_d,
  input  logic                 wr_dr,
  input  logic [SELW-1:0]      dr_sel,
  input  logic [WW-1:0]        dr_d,
  input  logic                 step_en,
  input  logic                 step_up,
  output logic [WW-1:0]        wiper_q,
  output logic [NREG*WW-1:0]   dregs_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       wiper_q <= WC_RST;
    else if (wr_wc)   wiper_q <= wc_d;
    else if (step_en) wiper_q <= sat_step(wiper_q, step_up);

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_dreg
      logic [WW-1:0] r;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= '0;
        else if (wr_dr && (dr_sel == SELW'(g))) r <= dr_d;
      assign dregs_q[g*WW +: WW] = r;
    end
  endgenerate
endmodule

// File: rtl/dpot_cmd_fsm.sv
module dpot_cmd_fsm import dpot_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_s,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic [2:0]         strap_i,
  input  logic [WW-1:0]      wiper_i,
  input  logic [NREG*WW-1:0] dregs_i,
  output logic               sda_oe,
  output logic               ignoring,
  output logic               commit,
  output logic               wr_wc,
  output logic [WW-1:0]      wc_d,
  output logic               wr_dr,
  output logic [SELW-1:0]    dr_sel,
  output logic [WW-1:0]      dr_d,
  output logic               step_en,
  output logic               step_up
);
  state_e            st, rx_next;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, data, tx;
  logic [3:0]        op;
  logic [SELW-1:0]   rsel;
  logic              mnack, step_pend, step_bit, oe_c;

  always_comb begin
    case (st)
      S_ADDR:  rx_next = addr_match(sh, strap_i) ? S_ADDR_ACK : S_IGNORE;
      S_INSTR: rx_next = instr_ok(sh) ? S_INSTR_ACK : S_IGNORE;
      default: rx_next = S_DATA_ACK;
    endcase
  end

  always_comb begin
    case (st)
      S_ADDR_ACK, S_INSTR_ACK, S_DATA_ACK: oe_c = 1'b1;
      S_RD:                                oe_c = ~tx[BYTE_W-1];
      default:                             oe_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; data <= '0; tx <= '0;
      op <= '0; rsel <= '0; mnack <= 1'b0;
      step_pend <= 1'b0; step_bit <= 1'b0; sda_oe <= 1'b0;
    end else begin
      sda_oe <= oe_c;
      if (start_evt) begin
        st <= S_ADDR; cnt <= '0; step_pend <= 1'b0;
      end else if (stop_evt) begin
        st <= S_IDLE; cnt <= '0; step_pend <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_INSTR, S_DATA: begin
            if (scl_rise && cnt != CNT_W'(BYTE_W)) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
              cnt <= '0;
              st  <= rx_next;
              if (st == S_INSTR) begin
                op   <= sh[7:4];
                rsel <= sh[3:2];
                tx   <= (sh[7:4] == OP_RD_WC) ? wiper_i : pick_reg(dregs_i, sh[3:2]);
              end
              if (st == S_DATA) data <= sh;
            end
          end
          S_ADDR_ACK:  if (scl_fall) st <= S_INSTR;
          S_INSTR_ACK: if (scl_fall) st <= after_instr(op);
          S_DATA_ACK:  if (scl_fall) st <= S_HOLD;
          S_RD: begin
            if (scl_fall) begin
              if (cnt == CNT_W'(BYTE_W-1)) begin
                st <= S_RD_ACK; cnt <= '0;
              end else begin
                tx  <= {tx[BYTE_W-2:0], 1'b0};
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_RD_ACK: begin
            if (scl_rise) mnack <= sda_s;
            else if (scl_fall) begin
              if (mnack) st <= S_IGNORE;
              else begin
                st <= S_RD;
                tx <= (op == OP_RD_WC) ? wiper_i : pick_reg(dregs_i, rsel);
              end
            end
          end
          S_STEP: begin
            if (scl_rise) begin
              step_bit <= sda_s; step_pend <= 1'b1;
            end else if (scl_fall) step_pend <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign ignoring = (st == S_IGNORE);
  assign commit   = (st == S_HOLD) && stop_evt;
  assign step_en  = (st == S_STEP) && scl_fall && step_pend && !start_evt && !stop_evt;
  assign step_up  = step_bit;
  assign wr_dr    = commit && (op == OP_WR_DR || op == OP_WC2DR);
  assign wr_wc    = commit && (op == OP_WR_WC || op == OP_DR2WC);
  assign dr_sel   = rsel;
  assign dr_d     = (op == OP_WR_DR) ? data : wiper_i;
  assign wc_d     = (op == OP_WR_WC) ? data : pick_reg(dregs_i, rsel);
endmodule

// File: rtl/dpot_i2c_decoder.sv
module dpot_i2c_decoder import dpot_pkg::*; #(
  parameter int            SYNC_STAGES = 2,
  parameter logic [WW-1:0] WIPER_RST   = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [2:0]         strap_i,
  output logic               sda_oe,
  output logic [WW-1:0]      wiper_q,
  output logic [NREG*WW-1:0] dreg_q
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic ignoring, commit, wr_wc, wr_dr, step_en, step_up;
  logic [WW-1:0]   wc_d, dr_d;
  logic [SELW-1:0] dr_sel;

  dpot_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  dpot_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .strap_i(strap_i), .wiper_i(wiper_q), .dregs_i(dreg_q),
    .sda_oe(sda_oe), .ignoring(ignoring), .commit(commit),
    .wr_wc(wr_wc), .wc_d(wc_d), .wr_dr(wr_dr), .dr_sel(dr_sel), .dr_d(dr_d),
    .step_en(step_en), .step_up(step_up));

  dpot_regs #(.WC_RST(WIPER_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_wc(wr_wc), .wc_d(wc_d),
    .wr_dr(wr_dr), .dr_sel(dr_sel), .dr_d(dr_d),
    .step_en(step_en), .step_up(step_up),
    .wiper_q(wiper_q), .dregs_q(dreg_q));
endmodule

// File: rtl/dpot_i2c_decoder_chk.sv
module dpot_i2c_decoder_chk import dpot_pkg::*; (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_s,
  input logic [WW-1:0] wiper_q,
  input logic          step_en,
  input logic          step_up,
  input logic          commit,
  input logic          stop_evt,
  input logic          ignoring
);
  a_r2_drive_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r3_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  a_r9_step_up_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && wiper_q != {WW{1'b1}}) |=> wiper_q == $past(wiper_q) + 1'b1);

  a_r9_step_down_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up && wiper_q != '0) |=> wiper_q == $past(wiper_q) - 1'b1);

  a_r10_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && wiper_q == {WW{1'b1}}) |=> wiper_q == {WW{1'b1}});

  a_r10_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up && wiper_q == '0) |=> wiper_q == '0);

  a_r11_commit_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> stop_evt);

  a_r11_wiper_sources: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_q) |-> ($past(step_en) || $past(commit)));
endmodule

bind dpot_i2c_decoder dpot_i2c_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .wiper_q(wiper_q), .step_en(step_en), .step_up(step_up),
  .commit(commit), .stop_evt(stop_evt), .ignoring(ignoring));

// File: tb/dpot_i2c_decoder_tb.sv
module dpot_i2c_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [7:0] wiper_q;
  logic [31:0] dreg_q;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] mw;
  logic [7:0] md [4];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  dpot_i2c_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(STRAP), .sda_oe(sda_oe), .wiper_q(wiper_q), .dreg_q(dreg_q));

  function automatic bit b_addr_ok(input logic [7:0] b);
    return b[7:4] == 4'b0101 && b[3:1] == STRAP;
  endfunction

  function automatic bit b_instr_ok(input logic [7:0] b);
    logic [3:0] o = b[7:4];
    bit known = (o == 4'b1001 || o == 4'b1100 || o == 4'b1010 || o == 4'b1011 ||
                 o == 4'b1101 || o == 4'b1110 || o == 4'b0010);
    bit needs0 = (o == 4'b1010 || o == 4'b1011 || o == 4'b1101 ||
                  o == 4'b1110 || o == 4'b0010);
    return known && (!needs0 || b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] b_step(input logic [7:0] w, input bit up);
    int v = int'(w) + (up ? 1 : -1);
    if (v > 255) v = 255;
    if (v < 0) v = 0;
    return v[7:0];
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'b1100: return "R5";
      4'b1011: return "R6";
      4'b1101, 4'b1110: return "R7";
      4'b1001, 4'b1010: return "R8";
      4'b0010: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_regs(input string tag);
    chk(wiper_q == mw, {tag, " wiper"}, wiper_q, mw);
    for (int i = 0; i < 4; i++)
      chk(dreg_q[i*8 +: 8] == md[i], {tag, " data register"}, dreg_q[i*8 +: 8], md[i]);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; hold(Q); scl_m = 1'b1; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q/2);
    ack = (sda_line == 1'b0);
    hold(Q - Q/2); scl_m = 1'b0; hold(Q);
  endtask

  task automatic recv_byte(input bit m_nack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q/2);
      v[i] = sda_line;
      hold(Q - Q/2); scl_m = 1'b0; hold(Q);
    end
    send_bit(m_nack);
  endtask

  // mode: 0 random step directions, 1 all up, 2 all down
  task automatic txn(input logic [7:0] ab, input logic [7:0] ib, input logic [7:0] db,
                     input int nst, input int mode);
    bit ack;
    logic [7:0] rv, ev;
    logic [3:0] o;
    int sel;
    o = ib[7:4];
    sel = int'(ib[3:2]);
    bus_start();
    send_byte(ab, ack);
    chk(ack == b_addr_ok(ab), "R2 address acknowledge", ack, b_addr_ok(ab));
    if (!b_addr_ok(ab)) begin
      send_byte(ib, ack);
      chk(!ack, "R3 byte after mismatch acknowledged", ack, 0);
      bus_stop();
      check_regs("R3");
      return;
    end
    send_byte(ib, ack);
    chk(ack == b_instr_ok(ib), "R4 instruction acknowledge", ack, b_instr_ok(ib));
    if (!b_instr_ok(ib)) begin
      send_byte(db, ack);
      chk(!ack, "R4 byte after refused instruction", ack, 0);
      bus_stop();
      check_regs("R4");
      return;
    end
    case (o)
      4'b1100: begin
        send_byte(db, ack); chk(ack, "R5 data acknowledge", ack, 1);
        bus_stop(); md[sel] = db;
      end
      4'b1011: begin
        send_byte(db, ack); chk(ack, "R6 data acknowledge", ack, 1);
        bus_stop(); mw = db;
      end
      4'b1101: begin bus_stop(); mw = md[sel]; end
      4'b1110: begin bus_stop(); md[sel] = mw; end
      4'b1001, 4'b1010: begin
        ev = (o == 4'b1010) ? mw : md[sel];
        recv_byte(1'b0, rv); chk(rv == ev, "R8 read first byte", rv, ev);
        recv_byte(1'b1, rv); chk(rv == ev, "R8 read repeated byte", rv, ev);
        bus_stop();
        chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
      end
      default: begin
        for (int i = 0; i < nst; i++) begin
          bit up = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : bit'($urandom % 2);
          send_bit(up);
          mw = b_step(mw, up);
        end
        bus_stop();
      end
    endcase
    check_regs(tag_of(o));
  endtask

  logic [3:0] op_pool [9] = '{4'b1001, 4'b1100, 4'b1010, 4'b1011, 4'b1101,
                              4'b1110, 4'b0010, 4'b0111, 4'b1111};

  initial begin
    int unsigned seed_set;
    bit ack;
    seed_set = $urandom(32'd5150);
    mw = '0;
    for (int i = 0; i < 4; i++) md[i] = '0;
    hold(5);
    rst_n = 1'b1;
    hold(5);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 SDA released", sda_oe, 0);
    check_regs("R1");

    // directed writes to seed values
    for (int i = 0; i < 4; i++)
      txn({4'b0101, STRAP, 1'b0}, {4'b1100, 2'(i), 2'(i)}, 8'(8'h31 * (i + 1)), 0, 0);
    txn({4'b0101, STRAP, 1'b1}, 8'b1011_0000, 8'hA5, 0, 0);
    // R3 mismatched strap bits
    txn({4'b0101, ~STRAP, 1'b0}, 8'b1011_0000, 8'h00, 0, 0);
    // R4 wiper write with nonzero pot select is refused
    txn({4'b0101, STRAP, 1'b0}, 8'b1011_0001, 8'h11, 0, 0);
    // R10 saturation at the top rail
    txn({4'b0101, STRAP, 1'b0}, 8'b1011_0000, 8'd250, 0, 0);
    txn({4'b0101, STRAP, 1'b0}, 8'b0010_0000, 8'h00, 10, 1);
    chk(wiper_q == 8'd255, "R10 clamp at top", wiper_q, 255);
    // R10 saturation at the bottom rail
    txn({4'b0101, STRAP, 1'b0}, 8'b1011_0000, 8'd3, 0, 0);
    txn({4'b0101, STRAP, 1'b0}, 8'b0010_0000, 8'h00, 8, 2);
    chk(wiper_q == 8'd0, "R10 clamp at bottom", wiper_q, 0);

    // R11 STOP inside the data byte
    bus_start(); send_byte({4'b0101, STRAP, 1'b0}, ack);
    send_byte(8'b1100_1000, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop(); check_regs("R11 stop mid byte");
    // R11 START inside the instruction byte
    bus_start(); send_byte({4'b0101, STRAP, 1'b0}, ack);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_start(); bus_stop(); check_regs("R11 start mid byte");
    // R11 START in place of the closing STOP
    bus_start(); send_byte({4'b0101, STRAP, 1'b0}, ack);
    send_byte(8'b1100_0100, ack); send_byte(8'h5A, ack);
    bus_start(); bus_stop(); check_regs("R11 start before commit");
    bus_start(); send_byte({4'b0101, STRAP, 1'b0}, ack);
    send_byte(8'b1101_1100, ack);
    bus_start(); bus_stop(); check_regs("R11 transfer abandoned");

    // constrained random commands
    for (int n = 0; n < 45; n++) begin
      logic [7:0] ab, ib;
      logic [1:0] pot;
      ab = ($urandom % 5 != 0) ? {4'b0101, STRAP, 1'(($urandom % 2))} : 8'($urandom);
      pot = ($urandom % 4 != 0) ? 2'b00 : 2'($urandom);
      ib = {op_pool[$urandom % 9], 2'($urandom), pot};
      txn(ab, ib, 8'($urandom), 1 + int'($urandom % 16), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule